// File: doc/BRIEF.md
# Interrupt Vector Fetch Unit

This block resolves an 8-bit interrupt vector number into the entry point of its service routine. It reads the entry from a vector table held in byte-wide memory, one byte per accepted read. A mode input picks one of two table layouts.

In real mode the table sits at a fixed place in low memory. Its entries are 4 bytes long, and the block forms a 20-bit physical address from the segment and offset it reads. In protected mode the table can sit anywhere. Its base comes from a table-base input, its entries are 8-byte descriptors, and the block returns a 16-bit selector, a 32-bit offset and the attribute byte.

A caller presents a vector with a one-cycle start request. It then waits for a one-cycle completion pulse, at which point the result outputs are valid. The block raises a reserved flag for vectors that fall in the range the active mode keeps for processor exceptions, and it fetches those vectors all the same.

Top module: `ivec_fetch`

## Requirements
- R1: After a synchronous active-low reset, busy_o, done_o and mem_rd_o are 0, and sel_o, off_o, attr_o, phys_o and reserved_o are all 0. A reset during a fetch returns the block to idle.
- R2: In real mode (prot_mode_i = 0), the block reads exactly 4 bytes at addresses vector×4 + 0, +1, +2, +3, in ascending order. Every address stays below 0x400.
- R3: In protected mode (prot_mode_i = 1), the block reads exactly 8 bytes at addresses base + vector×8 + 0 … +7, in ascending order, with the sum wrapping modulo 2^32.
- R4: In real mode, bytes 0–1 of the entry form the offset and bytes 2–3 form the segment, each little-endian (low byte at the lower address). sel_o carries the segment, off_o carries the offset zero-extended, and attr_o is 0.
- R5: In real mode, phys_o = (segment×16 + offset) mod 2^20. Segment 0x4A3C with offset 0x332A (vector 0x42) gives 0x4D6EA. In protected mode phys_o is 0.
- R6: In protected mode, off_o = {byte7, byte6, byte1, byte0}, sel_o = {byte3, byte2} and attr_o = byte5.
- R7: While mem_rd_o is high and mem_ready_i is low, the read address holds and no byte is taken.
- R8: done_o is a one-cycle pulse. It comes in the cycle after the last byte is accepted, with mem_rd_o low.
- R9: reserved_o is 1 when the vector is below 32 in protected mode, or below 5 in real mode, and 0 otherwise. The fetch proceeds in either case.
- R10: A start request, vector, mode or base change while busy_o is high has no effect on the fetch in progress.
- R11: After done_o, the result outputs hold their values until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| vector_i | input | 8 | Interrupt vector number |
| prot_mode_i | input | 1 | 0 = real-mode layout, 1 = protected-mode layout |
| tbl_base_i | input | 32 | Protected-mode table base address |
| busy_o | output | 1 | Fetch in progress (including the completion cycle) |
| mem_rd_o | output | 1 | Byte read request |
| mem_addr_o | output | 32 | Byte read address |
| mem_ready_i | input | 1 | Memory accepts the read and supplies data this cycle |
| mem_data_i | input | 8 | Read data byte |
| done_o | output | 1 | One-cycle completion pulse |
| reserved_o | output | 1 | Vector lies in the reserved range of the active mode |
| sel_o | output | 16 | Segment (real) or selector (protected) |
| off_o | output | 32 | Routine offset |
| attr_o | output | 8 | Descriptor attribute byte (protected mode only) |
| phys_o | output | 20 | Real-mode physical entry address |

## Verification
A corrupted byte index or latched vector shows up on mem_addr_o in the very next read cycle, as a skipped, repeated or misplaced address. The bench compares every read cycle against the arithmetic expectation. A wrong byte-lane placement or endianness slip leaves the addresses correct but corrupts sel_o, off_o or phys_o in the done cycle, which is checked for every vector in both modes with a memory whose contents depend on the address. A controller that miscounts the bytes per mode, or leaks the inputs while busy, moves or misses the done pulse or changes the result within a single fetch.

// File: rtl/ivec_pkg.sv
// Shared constants and types for the interrupt vector fetch unit.
// Assumes byte-addressed memory and at most 8 bytes per table entry.
package ivec_pkg;
    localparam int REAL_ENTRY_BYTES = 4;
    localparam int PROT_ENTRY_BYTES = 8;
    localparam int MAX_ENTRY_BYTES  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/ivec_addr.sv
// Byte address generator for one table entry.
// Real layout: fixed table at address 0, entry = vector << REAL_SH.
// Protected layout: entry = base + (vector << PROT_SH), wrapping at ADDR_W bits.
// Assumes idx_i stays below the entry size of the selected layout.
module ivec_addr #(
    parameter int VEC_W   = 8,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 3,
    parameter int REAL_SH = 2,
    parameter int PROT_SH = 3
) (
    input  logic              prot_mode_i,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] real_off;
    logic [ADDR_W-1:0] prot_off;

    // Select the layout and add the byte index to the entry start.
    always_comb begin
        real_off = ADDR_W'(vec_i) << REAL_SH;
        prot_off = ADDR_W'(vec_i) << PROT_SH;
        if (prot_mode_i)
            addr_o = base_i + prot_off + ADDR_W'(idx_i);
        else
            addr_o = real_off + ADDR_W'(idx_i);
    end
endmodule

// File: rtl/ivec_assemble.sv
// Field assembler: turns the collected little-endian entry bytes into
// selector/segment, offset, attribute and the real-mode physical address.
// Assumes entry_i holds byte k at bits [8k+7:8k].
module ivec_assemble #(
    parameter int PHYS_W  = 20,
    parameter int ENTRY_W = 64
) (
    input  logic               prot_mode_i,
    input  logic [ENTRY_W-1:0] entry_i,
    output logic [15:0]        sel_o,
    output logic [31:0]        off_o,
    output logic [7:0]         attr_o,
    output logic [PHYS_W-1:0]  phys_o
);
    logic [15:0]       lo_half;
    logic [15:0]       mid_half;
    logic [15:0]       top_half;
    logic [PHYS_W-1:0] seg_phys;

    // Split the entry into halves and build the per-mode fields.
    always_comb begin
        lo_half  = entry_i[15:0];
        mid_half = entry_i[31:16];
        top_half = entry_i[63:48];
        seg_phys = PHYS_W'({mid_half, 4'h0}) + PHYS_W'(lo_half);
        sel_o    = mid_half;
        if (prot_mode_i) begin
            off_o  = {top_half, lo_half};
            attr_o = entry_i[47:40];
            phys_o = '0;
        end else begin
            off_o  = {16'h0000, lo_half};
            attr_o = 8'h00;
            phys_o = seg_phys;
        end
    end
endmodule

// File: rtl/ivec_fetch.sv
// Interrupt vector fetch unit (top).
// Takes a start request while idle, latches vector/mode/base, reads the
// table entry one byte per ready cycle, then pulses done for one cycle.
// Assumes memory data is valid in the same cycle as mem_ready_i.
module ivec_fetch
    import ivec_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int ADDR_W   = 32,
    parameter int PHYS_W   = 20,
    parameter int REAL_RSV = 5,
    parameter int PROT_RSV = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VEC_W-1:0]  vector_i,
    input  logic              prot_mode_i,
    input  logic [ADDR_W-1:0] tbl_base_i,
    output logic              busy_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_ready_i,
    input  logic [7:0]        mem_data_i,
    output logic              done_o,
    output logic              reserved_o,
    output logic [15:0]       sel_o,
    output logic [31:0]       off_o,
    output logic [7:0]        attr_o,
    output logic [PHYS_W-1:0] phys_o
);
    localparam int IDX_W   = $clog2(MAX_ENTRY_BYTES);
    localparam int ENTRY_W = 8 * MAX_ENTRY_BYTES;
    localparam int REAL_SH = $clog2(REAL_ENTRY_BYTES);
    localparam int PROT_SH = $clog2(PROT_ENTRY_BYTES);

    fetch_state_t       state_q;
    logic [IDX_W-1:0]   idx_q;
    logic [VEC_W-1:0]   vec_q;
    logic               mode_q;
    logic [ADDR_W-1:0]  base_q;
    logic [ENTRY_W-1:0] entry_q;
    logic               resv_q;
    logic [IDX_W-1:0]   last_idx;
    logic               is_last;
    logic               vec_resv;

    // Last byte index of the active layout and the reserved-range test.
    always_comb begin
        last_idx = mode_q ? IDX_W'(PROT_ENTRY_BYTES - 1) : IDX_W'(REAL_ENTRY_BYTES - 1);
        is_last  = (idx_q == last_idx);
        vec_resv = prot_mode_i ? (int'(vector_i) < PROT_RSV) : (int'(vector_i) < REAL_RSV);
    end

    // Sequencer: accept start, collect bytes, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            vec_q   <= '0;
            mode_q  <= 1'b0;
            base_q  <= '0;
            entry_q <= '0;
            resv_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        vec_q   <= vector_i;
                        mode_q  <= prot_mode_i;
                        base_q  <= tbl_base_i;
                        resv_q  <= vec_resv;
                        idx_q   <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ready_i) begin
                        entry_q[int'(idx_q)*8 +: 8] <= mem_data_i;
                        if (is_last) state_q <= ST_DONE;
                        else         idx_q   <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Status outputs decoded from the sequencer state.
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        mem_rd_o   = (state_q == ST_FETCH);
        done_o     = (state_q == ST_DONE);
        reserved_o = resv_q;
    end

    ivec_addr #(
        .VEC_W(VEC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .REAL_SH(REAL_SH), .PROT_SH(PROT_SH)
    ) u_addr (
        .prot_mode_i(mode_q),
        .vec_i      (vec_q),
        .base_i     (base_q),
        .idx_i      (idx_q),
        .addr_o     (mem_addr_o)
    );

    ivec_assemble #(
        .PHYS_W(PHYS_W), .ENTRY_W(ENTRY_W)
    ) u_asm (
        .prot_mode_i(mode_q),
        .entry_i    (entry_q),
        .sel_o      (sel_o),
        .off_o      (off_o),
        .attr_o     (attr_o),
        .phys_o     (phys_o)
    );

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o && mem_ready_i && !is_last |=> mem_addr_o == $past(mem_addr_o) + 1'b1); // R2
    AST_REAL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o && !mode_q |-> mem_addr_o < ADDR_W'(32'h400)); // R2
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o && !mem_ready_i |=> mem_rd_o && $stable(mem_addr_o)); // R7
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o && mem_ready_i && is_last |=> done_o && !mem_rd_o); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_VEC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> $stable(vec_q) && $stable(mode_q) && $stable(base_q)); // R10
    AST_PHYS_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !mode_q |-> phys_o[3:0] == off_o[3:0]); // R5
endmodule

// File: tb/ivec_fetch_test.sv
`timescale 1ns/1ps
module ivec_fetch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  vector_i = 8'h00;
    logic        prot_mode_i = 1'b0;
    logic [31:0] tbl_base_i = 32'h0;
    logic        busy_o;
    logic        mem_rd_o;
    logic [31:0] mem_addr_o;
    logic        mem_ready_i = 1'b0;
    logic [7:0]  mem_data_i;
    logic        done_o;
    logic        reserved_o;
    logic [15:0] sel_o;
    logic [31:0] off_o;
    logic [7:0]  attr_o;
    logic [19:0] phys_o;

    integer n_checks = 0;
    integer n_fail   = 0;
    logic [7:0] lfsr = 8'hA5;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ivec_fetch uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vector_i(vector_i),
        .prot_mode_i(prot_mode_i), .tbl_base_i(tbl_base_i), .busy_o(busy_o),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_ready_i(mem_ready_i),
        .mem_data_i(mem_data_i), .done_o(done_o), .reserved_o(reserved_o),
        .sel_o(sel_o), .off_o(off_o), .attr_o(attr_o), .phys_o(phys_o)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        case (a)
            32'h108: return 8'h2A;
            32'h109: return 8'h33;
            32'h10A: return 8'h3C;
            32'h10B: return 8'h4A;
            default: return a[7:0] * 8'd13 + a[15:8] * 8'd5 + a[23:16] + a[31:24] * 8'd3 + 8'h21;
        endcase
    endfunction

    // Memory model: data follows the requested address.
    always_comb mem_data_i = mem_byte(mem_addr_o);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_fetch(input bit mode, input logic [7:0] vec, input logic [31:0] base, input bit interfere);
        int n;
        int k;
        int cyc;
        int bad;
        logic [31:0] start_a;
        logic [31:0] bad_act;
        logic [31:0] bad_exp;
        logic [7:0]  b [8];
        logic [15:0] e_sel;
        logic [31:0] e_off;
        logic [7:0]  e_attr;
        logic [19:0] e_phys;
        bit e_resv;
        n = mode ? 8 : 4;
        start_a = mode ? base + {21'd0, vec, 3'b000} : {22'd0, vec, 2'b00};
        @(negedge clk);
        prot_mode_i = mode; vector_i = vec; tbl_base_i = base; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 0; cyc = 0; bad = 0; bad_act = 0; bad_exp = 0;
        while (k < n && cyc < 64) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_ready_i = (lfsr[1:0] != 2'b00);
            if (interfere && cyc == 1) begin
                start_i = 1'b1; vector_i = ~vec; prot_mode_i = ~mode; tbl_base_i = base ^ 32'h55;
            end else begin
                start_i = 1'b0;
            end
            if (!mem_rd_o || done_o || mem_addr_o != start_a + k) begin
                if (bad == 0) begin bad_act = mem_addr_o; bad_exp = start_a + k; end
                bad++;
            end
            if (mem_ready_i) k++;
            cyc++;
            @(negedge clk);
        end
        mem_ready_i = 1'b0; start_i = 1'b0;
        check(bad == 0, mode ? "R3 R7 R10 address sequence" : "R2 R7 R10 address sequence",
              {32'h0, bad_act}, {32'h0, bad_exp});
        check(done_o && !mem_rd_o, "R8 done after last byte", {62'h0, done_o, mem_rd_o}, 64'h2);
        for (int i = 0; i < 8; i++) b[i] = mem_byte(start_a + i);
        e_sel = {b[3], b[2]};
        if (mode) begin
            e_off  = {b[7], b[6], b[1], b[0]};
            e_attr = b[5];
            e_phys = 20'h0;
            e_resv = (vec < 8'd32);
        end else begin
            e_off  = {16'h0, b[1], b[0]};
            e_attr = 8'h00;
            e_phys = 20'(({12'h0, e_sel} << 4) + {16'h0, e_off[15:0]});
            e_resv = (vec < 8'd5);
        end
        check(sel_o == e_sel && off_o == e_off, mode ? "R6 selector/offset" : "R4 segment/offset",
              {16'h0, sel_o, off_o}, {16'h0, e_sel, e_off});
        check(attr_o == e_attr, mode ? "R6 attribute" : "R4 attribute zero", {56'h0, attr_o}, {56'h0, e_attr});
        check(phys_o == e_phys, "R5 physical address", {44'h0, phys_o}, {44'h0, e_phys});
        check(reserved_o == e_resv, "R9 reserved flag", {63'h0, reserved_o}, {63'h0, e_resv});
        @(negedge clk);
        check(!done_o, "R8 done single cycle", {63'h0, done_o}, 64'h0);
        @(negedge clk);
        check(sel_o == e_sel && off_o == e_off && phys_o == e_phys && attr_o == e_attr,
              "R11 result held", {16'h0, sel_o, off_o}, {16'h0, e_sel, e_off});
    endtask

    initial begin
        #(200000 * 5.0);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy_o && !done_o && !mem_rd_o, "R1 idle after reset",
              {61'h0, busy_o, done_o, mem_rd_o}, 64'h0);
        check(sel_o == 0 && off_o == 0 && attr_o == 0 && phys_o == 0 && !reserved_o,
              "R1 results zero after reset", {16'h0, sel_o, off_o}, 64'h0);

        // R5: worked example, vector 0x42
        run_fetch(1'b0, 8'h42, 32'h0, 1'b0);
        check(phys_o == 20'h4D6EA, "R5 vector 42h example", {44'h0, phys_o}, 64'h4D6EA);

        // R10: inputs disturbed while busy
        run_fetch(1'b0, 8'h07, 32'h0, 1'b1);
        run_fetch(1'b1, 8'h21, 32'h0004_0000, 1'b1);

        // R2 R4 R9: full real-mode sweep
        for (int v = 0; v < 256; v++) run_fetch(1'b0, 8'(v), 32'hDEAD_0000, 1'b0);
        // R3 R6 R9: full protected-mode sweep
        for (int v = 0; v < 256; v++) run_fetch(1'b1, 8'(v), 32'h0012_3450, 1'b0);
        // R3: base plus offset wraps modulo 2^32
        for (int v = 200; v < 256; v++) run_fetch(1'b1, 8'(v), 32'hFFFF_F900, 1'b0);

        // R1: reset in the middle of a fetch
        @(negedge clk);
        prot_mode_i = 1'b1; vector_i = 8'h40; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(!busy_o && !mem_rd_o && !done_o, "R1 reset aborts fetch",
              {61'h0, busy_o, done_o, mem_rd_o}, 64'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule